// File: doc/BRIEF.md
# Frame CRC Checker

This block sits on the receive side of a serial link, after the 8b/10b decoder. Each clock it takes one decoded 32-bit word and a flag saying the most significant byte is a control character. It watches the stream for a start-of-frame ordered set. It then divides every following data word by the 32-bit frame CRC polynomial. When the frame is closed by an end-of-frame or any other ordered set, it gives a verdict.

The verdict is a one-cycle ready pulse on the cycle after the closing word. An ok flag rides in the same cycle when the division register holds the good-frame residue. Optionally, idle ordered sets inside an open frame can be stepped over. This lets a transmitter pause a frame and resume it later without disturbing the check. A raw bypass mode and the enable input both silence the checker.

Top module: `fcc_top`

## Requirements
- R1: While `chk_en` is low, no ready pulse is produced. Any open frame is dropped: a closing ordered set that arrives after `chk_en` returns high gives no report.
- R2: A start-of-frame is a word with `rx_ctrl` high whose bytes are, from bit 31 down, 0xBC, then 0xB5, then one of 0x17, 0x57, 0x37, 0x55, 0x35, 0x56, 0x36 or 0x58 (bits 7:0 are not examined). Division starts with the next word.
- R3: While a frame is open, a word with `rx_ctrl` high that is neither a start-of-frame nor a skipped idle closes the frame. `crc_ready` is high for exactly the one cycle that follows that word.
- R4: The division register is preset to 0xFFFFFFFF. Each data word (`rx_ctrl` low) is shifted in bit 31 first with polynomial 0x04C11DB7. `crc_ok` is high together with `crc_ready` only when the register holds 0xC704DD7B, which is the state left by the data followed by the complement of its CRC.
- R5: With `idle_skip_en` high, idle words inside an open frame leave the register and the frame untouched. Two idle words count: 0xBC95B5B5, and 0xBCB5B5B5, which is recognised as an idle only while `idle_skip_en` is high. With `idle_skip_en` low, an idle closes the frame like any other ordered set.
- R6: While `raw_mode` is high, the checker is bypassed: no ready pulse is produced and any open frame is dropped.
- R7: An ordered set that arrives while no frame is open produces no ready pulse.
- R8: A start-of-frame inside an open frame presets the register again and produces no report. Only the words after the latest start-of-frame are checked.
- R9: After reset, `crc_ready` and `crc_ok` are low and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 32 | Decoded word, first byte in bits 31:24 |
| rx_ctrl | input | 1 | Bits 31:24 of `rx_word` are a control character |
| chk_en | input | 1 | Enables CRC checking |
| idle_skip_en | input | 1 | Idles inside a frame are stepped over |
| raw_mode | input | 1 | Raw bypass; checker silent |
| crc_ready | output | 1 | One-cycle pulse after a frame closes |
| crc_ok | output | 1 | Frame remainder passed; valid with `crc_ready` |

## Verification
Good frames are swept over payload lengths from empty to a dozen words. Every start-of-frame code is used, and both end-of-frame and other closing ordered sets appear, so the remainder path and the close timing are seen in every combination. Single-bit corruptions are placed in each data position and in the CRC word, which separates a passing residue from a near miss. Targeted sequences then cover idles inside a frame with skipping on and off, including the positive form that counts only when skipping is on. They also cover closing words with no frame open, a restart by a second start-of-frame, and frames sent under raw mode or with the enable dropped mid-frame, each of which must stay silent.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t data;
        logic  ctrl;
    } rx_beat_t;

    typedef enum logic [2:0] {
        WK_DATA,
        WK_SOF,
        WK_IDLE,
        WK_OTHER
    } word_kind_e;

    typedef enum logic {
        FR_CLOSED,
        FR_OPEN
    } frame_state_e;

    localparam logic [7:0] COMMA_BYTE = 8'hBC;
    localparam logic [7:0] SOF_MARK   = 8'hB5;
    localparam word_t      IDLE_NEG   = 32'hBC95B5B5;
    localparam word_t      IDLE_POS   = 32'hBCB5B5B5;

    function automatic logic sof_class_code(input logic [7:0] b);
        case (b)
            8'h17, 8'h57, 8'h37, 8'h55,
            8'h35, 8'h56, 8'h36, 8'h58: sof_class_code = 1'b1;
            default:                    sof_class_code = 1'b0;
        endcase
    endfunction

    function automatic word_t crc_word_step(input word_t state, input word_t data,
                                            input word_t poly);
        word_t r;
        logic  fb;
        r = state;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[WORD_W-1] ^ data[i];
            r  = {r[WORD_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/fcc_word_class.sv
module fcc_word_class
    import fcc_pkg::*;
(
    input  rx_beat_t   beat,
    input  logic       idle_skip_en,
    output word_kind_e kind
);
    logic comma_lead;
    logic is_sof;
    logic is_idle;

    always_comb begin
        comma_lead = beat.data[31:24] == COMMA_BYTE;
        is_sof     = beat.ctrl && comma_lead && (beat.data[23:16] == SOF_MARK)
                     && sof_class_code(beat.data[15:8]);
        is_idle    = beat.ctrl && ((beat.data == IDLE_NEG) ||
                                   (idle_skip_en && beat.data == IDLE_POS));
        if (!beat.ctrl)   kind = WK_DATA;
        else if (is_sof)  kind = WK_SOF;
        else if (is_idle) kind = WK_IDLE;
        else              kind = WK_OTHER;
    end
endmodule

// File: rtl/fcc_crc_reg.sv
module fcc_crc_reg
    import fcc_pkg::*;
#(
    parameter word_t POLY = 32'h04C11DB7,
    parameter word_t SEED = 32'hFFFFFFFF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  preset,
    input  logic  advance,
    input  word_t data,
    output word_t state
);
    word_t state_q;

    always_ff @(posedge clk) begin
        if (rst || preset)
            state_q <= SEED;
        else if (advance)
            state_q <= crc_word_step(state_q, data, POLY);
    end

    assign state = state_q;
endmodule

// File: rtl/fcc_frame_ctl.sv
module fcc_frame_ctl
    import fcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       idle_skip_en,
    input  word_kind_e kind,
    output logic       preset,
    output logic       advance,
    output logic       close_now,
    output logic       frame_open
);
    frame_state_e st_q, st_d;

    always_comb begin
        st_d      = st_q;
        preset    = 1'b0;
        advance   = 1'b0;
        close_now = 1'b0;
        if (!active) begin
            st_d = FR_CLOSED;
        end else if (kind == WK_SOF) begin
            st_d   = FR_OPEN;
            preset = 1'b1;
        end else if (st_q == FR_OPEN) begin
            case (kind)
                WK_DATA: advance = 1'b1;
                WK_IDLE: begin
                    if (!idle_skip_en) begin
                        close_now = 1'b1;
                        st_d      = FR_CLOSED;
                    end
                end
                default: begin
                    close_now = 1'b1;
                    st_d      = FR_CLOSED;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= FR_CLOSED;
        else     st_q <= st_d;
    end

    assign frame_open = st_q == FR_OPEN;
endmodule

// File: rtl/fcc_top.sv
module fcc_top
    import fcc_pkg::*;
#(
    parameter word_t POLY    = 32'h04C11DB7,
    parameter word_t SEED    = 32'hFFFFFFFF,
    parameter word_t RESIDUE = 32'hC704DD7B
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] rx_word,
    input  logic        rx_ctrl,
    input  logic        chk_en,
    input  logic        idle_skip_en,
    input  logic        raw_mode,
    output logic        crc_ready,
    output logic        crc_ok
);
    rx_beat_t   beat;
    word_kind_e kind;
    word_t      crc_state;
    logic       active, preset, advance, close_now, frame_open;
    logic       ready_q, ok_q;

    assign beat   = '{data: rx_word, ctrl: rx_ctrl};
    assign active = chk_en && !raw_mode;

    fcc_word_class u_class (
        .beat         (beat),
        .idle_skip_en (idle_skip_en),
        .kind         (kind)
    );

    fcc_frame_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .active       (active),
        .idle_skip_en (idle_skip_en),
        .kind         (kind),
        .preset       (preset),
        .advance      (advance),
        .close_now    (close_now),
        .frame_open   (frame_open)
    );

    fcc_crc_reg #(.POLY(POLY), .SEED(SEED)) u_crc (
        .clk     (clk),
        .rst     (rst),
        .preset  (preset),
        .advance (advance),
        .data    (beat.data),
        .state   (crc_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            ready_q <= close_now;
            ok_q    <= close_now && (crc_state == RESIDUE);
        end
    end

    assign crc_ready = ready_q;
    assign crc_ok    = ok_q;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker (
    input logic clk,
    input logic rst,
    input logic rx_ctrl,
    input logic chk_en,
    input logic raw_mode,
    input logic frame_open,
    input logic crc_ready,
    input logic crc_ok
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        crc_ready |=> !crc_ready);

    a_r3_closed_by_ctrl: assert property (@(posedge clk) disable iff (rst)
        crc_ready |-> $past(rx_ctrl));

    a_r4_ok_with_ready: assert property (@(posedge clk) disable iff (rst)
        crc_ok |-> crc_ready);

    a_r1_enable_needed: assert property (@(posedge clk) disable iff (rst)
        crc_ready |-> $past(chk_en));

    a_r6_raw_silent: assert property (@(posedge clk) disable iff (rst)
        crc_ready |-> !$past(raw_mode));

    a_r7_open_needed: assert property (@(posedge clk) disable iff (rst)
        crc_ready |-> $past(frame_open));

    a_r9_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!crc_ready && !crc_ok && !frame_open));
endmodule

bind fcc_top fcc_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .rx_ctrl    (rx_ctrl),
    .chk_en     (chk_en),
    .raw_mode   (raw_mode),
    .frame_open (frame_open),
    .crc_ready  (crc_ready),
    .crc_ok     (crc_ok)
);

// File: tb/fcc_top_test.sv
module fcc_top_test;
    localparam logic [31:0] RES      = 32'hC704DD7B;
    localparam logic [31:0] EOF_N    = 32'hBC95D5D5;
    localparam logic [31:0] EOF_T    = 32'hBCB57575;
    localparam logic [31:0] RRDY     = 32'hBC954A4A;
    localparam logic [31:0] IDLE_N   = 32'hBC95B5B5;
    localparam logic [31:0] IDLE_P   = 32'hBCB5B5B5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rx_word = '0;
    logic        rx_ctrl = 1'b0;
    logic        chk_en = 1'b1;
    logic        idle_skip_en = 1'b0;
    logic        raw_mode = 1'b0;
    logic        crc_ready, crc_ok;
    int          n_checks = 0;
    int          n_fails = 0;
    logic [7:0]  sof_codes [8] = '{8'h17, 8'h57, 8'h37, 8'h55, 8'h35, 8'h56, 8'h36, 8'h58};

    always #4 clk = ~clk;

    fcc_top uut (
        .clk(clk), .rst(rst), .rx_word(rx_word), .rx_ctrl(rx_ctrl),
        .chk_en(chk_en), .idle_skip_en(idle_skip_en), .raw_mode(raw_mode),
        .crc_ready(crc_ready), .crc_ok(crc_ok)
    );

    // polynomial long division, one bit at a time, MSB of the word first
    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
        logic [63:0] acc;
        acc = {c ^ d, 32'h0};
        for (int b = 63; b >= 32; b--)
            if (acc[b]) acc[b-:33] = acc[b-:33] ^ 33'h104C11DB7;
        return acc[31:0];
    endfunction

    function automatic logic [31:0] gen_word(input int seed, input int i);
        return (32'(i + 1) * 32'h9E3779B9) ^ (32'(seed) * 32'h7F4A7C15) ^ 32'h5A5A0F0F;
    endfunction

    task automatic step(input logic [31:0] w, input logic k,
                        input logic er, input logic eo, input string tag);
        rx_word = w;
        rx_ctrl = k;
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (crc_ready !== er || crc_ok !== eo) begin
            n_fails++;
            $display("FAIL %s: ready=%b ok=%b expected ready=%b ok=%b",
                     tag, crc_ready, crc_ok, er, eo);
        end
    endtask

    // bad_at: -1 none, 0..n-1 data word, n the CRC word
    task automatic send_frame(input logic [7:0] code, input int seed, input int n,
                              input int bad_at, input logic [31:0] closer,
                              input logic expect_rep, input string tag);
        logic [31:0] c, w;
        c = 32'hFFFFFFFF;
        step({8'hBC, 8'hB5, code, code}, 1'b1, 1'b0, 1'b0, tag);
        for (int i = 0; i < n; i++) begin
            w = gen_word(seed, i);
            c = ref_crc(c, w);
            step((i == bad_at) ? (w ^ (32'h1 << (i % 32))) : w, 1'b0, 1'b0, 1'b0, tag);
        end
        step((bad_at == n) ? (~c ^ 32'h0001_0000) : ~c, 1'b0, 1'b0, 1'b0, tag);
        step(closer, 1'b1, expect_rep, expect_rep && (bad_at < 0), tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: ran out of cycles");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] c, w;
        repeat (3) @(negedge clk);
        n_checks++;
        if (crc_ready !== 1'b0 || crc_ok !== 1'b0) begin
            n_fails++;
            $display("FAIL R9 in reset: ready=%b ok=%b expected 0 0", crc_ready, crc_ok);
        end
        rst = 1'b0;
        step(IDLE_N, 1'b1, 1'b0, 1'b0, "R9 quiet after reset");
        // R7: closing words with nothing open
        step(EOF_N, 1'b1, 1'b0, 1'b0, "R7 eof with no frame");
        step(RRDY, 1'b1, 1'b0, 1'b0, "R7 rrdy with no frame");

        // R2 R3 R4: length sweep, all SOF codes, two closers
        for (int n = 0; n <= 12; n++)
            send_frame(sof_codes[n % 8], n, n, -1, (n % 2) ? EOF_T : EOF_N, 1'b1, "R4 good frame");
        for (int s = 0; s < 8; s++)
            send_frame(sof_codes[s], 40 + s, 3, -1, RRDY, 1'b1, "R2 sof code / R3 rrdy close");
        // R4: single-bit errors at every position, incl. the CRC word
        for (int n = 1; n <= 8; n++)
            for (int b = 0; b <= n; b++)
                send_frame(sof_codes[b % 8], 100 + n, n, b, EOF_N, 1'b1, "R4 corrupted frame");
        // R3: second closer finds frame already closed
        step(EOF_N, 1'b1, 1'b0, 1'b0, "R3 no second pulse");
        // R2: near-miss SOF code is an ordinary ordered set
        step({8'hBC, 8'hB5, 8'h18, 8'h18}, 1'b1, 1'b0, 1'b0, "R2 non-sof code");
        step(32'h1234_5678, 1'b0, 1'b0, 1'b0, "R2 non-sof code");
        step(EOF_N, 1'b1, 1'b0, 1'b0, "R2 non-sof opened nothing");

        // R5: idles skipped inside frame
        idle_skip_en = 1'b1;
        c = 32'hFFFFFFFF;
        step(32'hBCB51717, 1'b1, 1'b0, 1'b0, "R5 skip");
        for (int i = 0; i < 6; i++) begin
            w = gen_word(7, i);
            c = ref_crc(c, w);
            step(w, 1'b0, 1'b0, 1'b0, "R5 skip data");
            step((i % 2) ? IDLE_P : IDLE_N, 1'b1, 1'b0, 1'b0, "R5 idle ignored");
        end
        step(~c, 1'b0, 1'b0, 1'b0, "R5 skip crc");
        step(IDLE_N, 1'b1, 1'b0, 1'b0, "R5 idle before close");
        step(EOF_N, 1'b1, 1'b1, 1'b1, "R5 good with idles");
        idle_skip_en = 1'b0;
        // R5: idles close the frame when skipping is off
        for (int v = 0; v < 2; v++) begin
            c = 32'hFFFFFFFF;
            step(32'hBCB53737, 1'b1, 1'b0, 1'b0, "R5 no skip");
            for (int i = 0; i < 3; i++) begin
                w = gen_word(20 + v, i);
                c = ref_crc(c, w);
                step(w, 1'b0, 1'b0, 1'b0, "R5 no skip data");
            end
            step(v ? IDLE_P : IDLE_N, 1'b1, 1'b1, c == RES, "R5 idle closes frame");
            step(EOF_N, 1'b1, 1'b0, 1'b0, "R5 closed already");
        end

        // R8: restart by a second SOF
        step(32'hBCB55757, 1'b1, 1'b0, 1'b0, "R8 first sof");
        step(32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, "R8 junk");
        step(32'h0BAD_F00D, 1'b0, 1'b0, 1'b0, "R8 junk");
        send_frame(8'h58, 9, 4, -1, EOF_T, 1'b1, "R8 restart then good frame");

        // R6: raw bypass
        raw_mode = 1'b1;
        send_frame(8'h17, 11, 3, -1, EOF_N, 1'b0, "R6 raw frame silent");
        step(32'hBCB51717, 1'b1, 1'b0, 1'b0, "R6 sof under raw");
        raw_mode = 1'b0;
        step(32'h0000_0001, 1'b0, 1'b0, 1'b0, "R6 data");
        step(EOF_N, 1'b1, 1'b0, 1'b0, "R6 raw sof opened nothing");
        send_frame(8'h36, 12, 2, -1, EOF_N, 1'b1, "R6 normal after raw");

        // R1: enable low
        chk_en = 1'b0;
        send_frame(8'h55, 13, 3, -1, EOF_N, 1'b0, "R1 disabled frame silent");
        chk_en = 1'b1;
        step(32'hBCB53535, 1'b1, 1'b0, 1'b0, "R1 sof");
        step(gen_word(14, 0), 1'b0, 1'b0, 1'b0, "R1 data");
        chk_en = 1'b0;
        step(gen_word(14, 1), 1'b0, 1'b0, 1'b0, "R1 drop mid frame");
        chk_en = 1'b1;
        step(gen_word(14, 2), 1'b0, 1'b0, 1'b0, "R1 data");
        step(EOF_N, 1'b1, 1'b0, 1'b0, "R1 dropped frame gives no report");
        send_frame(8'h56, 15, 5, -1, EOF_N, 1'b1, "R1 normal after enable");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule